// File: doc/BRIEF.md
# Serial Register Target with Deferred Readback

This block is a serial-bus target that gives an external host access to a small bank of 16-bit registers. It runs on a fast system clock and oversamples the host's serial clock, chip select and data-in lines. Each transaction is a 24-bit word sent most significant bit first. The top byte is a command: bit 7 selects read or write, and bits 6:0 give the register address. The low 16 bits carry the data word.

Read results are not returned in the same transaction. The block queues them and shifts them out at the start of the next select window. When no read is queued, the serial output replays the bits received in the previous window, delayed by 24 clock edges. This lets several targets be chained. A control bit turns the output off and makes the length check strict. A second control bit locks the block against all further commands. A status bit records discarded or rejected frames.

The frame engine runs a three-state machine: IDLE (select high), ACTIVE (select low, shifting) and DONE (one cycle that judges the frame). IDLE goes to ACTIVE when select is seen low, and the queued read word is loaded on that transition. ACTIVE goes to DONE when select is seen high. DONE always returns to IDLE, and on that step it either commits the frame to the register bank or flags it as bad.

Top module: `spi_reg_target`

## Requirements
- R1: A frame of exactly 24 bits with command bit 7 clear writes data bits 15:0 into the register at address bits 22:16. General registers sit at 0x04 to 0x07 and reset to 0x0000.
- R2: A frame with command bit 7 set reads the register at the address in bits 6:0, and its 16 data bits are ignored. During the next frame the output shifts out the command byte followed by the register value, MSB first.
- R3: When no read is queued, the output replays the previous frame's bits 24 serial clocks late. Clocks beyond 24 in one window pass the current frame's leading bits through.
- R4: While pass-through is on, a window of more than 24 bits is accepted, and the last 24 bits received are decoded.
- R5: A window with fewer than 24 bits is discarded and changes no register.
- R6: Setting bit 4 of register 0x03 holds `sdo_oe` low, and any window whose length is not exactly 24 bits is then discarded.
- R7: Writing 0x0001 to register 0x01 restores every register to its default. This includes register 0x03, so the output returns to enabled pass-through.
- R8: Setting bit 0 of register 0x03 rejects every later frame, including soft reset. Rejected frames are still replayed on the output in the next window. Only the hardware reset clears this lockout.
- R9: Bit 0 of read-only status register 0x0B is set by any discarded or rejected frame. Reading 0x0B clears it, and the read returns the value held before the clear. Writes to 0x0B are ignored.
- R10: Unimplemented addresses read as 0x0000 and ignore writes. The all-zero frame changes no register.
- R11: After hardware reset, `sdo_oe` and `sdo` are low and all registers hold 0x0000.
- R12: While select is low and the output is enabled, `sdo_oe` is high. SDI is sampled on the serial clock's falling edge, and `sdo` changes after its rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| sclk | input | 1 | Serial clock from host, idle low |
| cs_n | input | 1 | Active-low select |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host |
| sdo_oe | output | 1 | Output enable for the external tri-state pad |

## Verification
A write is followed by a read and then a no-op frame. This shows that the deferred readback differs from plain pass-through, which would replay the read command unchanged. A 32-bit window in pass-through mode checks both the last-24-bit decode and the 8-bit spill of the current frame's head. The same long window under output-off mode must be dropped. Short windows and the lockout are told apart through the status bit and through replayed rather than answered reads.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;
    localparam int FRAME_W = 24;
    localparam int CMD_W   = 8;
    localparam int DATA_W  = 16;

    localparam logic [6:0] ADDR_SRST = 7'h01;
    localparam logic [6:0] ADDR_CTRL = 7'h03;
    localparam logic [6:0] ADDR_STAT = 7'h0B;

    localparam int CTRL_LOCK_BIT = 0;
    localparam int CTRL_QUIET_BIT = 4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_DONE   = 2'd2
    } frame_state_e;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int W = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
    import spi_regs_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_s,
    input  logic               cs_n_s,
    input  logic               sdi_s,
    input  logic               quiet,
    input  logic               rd_pending,
    input  logic [FRAME_W-1:0] rd_word,
    output logic               sdo,
    output logic               sdo_oe,
    output logic               load_ack,
    output logic               commit,
    output logic               frame_bad,
    output logic [FRAME_W-1:0] frame_word
);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

    frame_state_e state_q, state_d;
    logic               sclk_d;
    logic               sclk_rise, sclk_fall;
    logic [FRAME_W-1:0] sr_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               sdo_q;
    logic               len_ok;

    assign sclk_rise = sclk_s & ~sclk_d;
    assign sclk_fall = ~sclk_s & sclk_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (!cs_n_s) state_d = ST_ACTIVE;
            ST_ACTIVE: if (cs_n_s)  state_d = ST_DONE;
            ST_DONE:                state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        len_ok     = quiet ? (cnt_q == CNT_FULL) : (cnt_q >= CNT_FULL);
        commit     = (state_q == ST_DONE) && len_ok;
        frame_bad  = (state_q == ST_DONE) && !len_ok;
        load_ack   = (state_q == ST_IDLE) && !cs_n_s && rd_pending;
        sdo_oe     = (state_q == ST_ACTIVE) && !quiet;
        sdo        = sdo_q;
        frame_word = sr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            sr_q   <= '0;
            cnt_q  <= '0;
            sdo_q  <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
            if (state_q == ST_IDLE && !cs_n_s) begin
                cnt_q <= '0;
                if (rd_pending) begin
                    sr_q  <= rd_word;
                    sdo_q <= rd_word[FRAME_W-1];
                end else begin
                    sdo_q <= sr_q[FRAME_W-1];
                end
            end else if (state_q == ST_ACTIVE) begin
                if (sclk_fall) begin
                    sr_q <= {sr_q[FRAME_W-2:0], sdi_s};
                    if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
                end
                if (sclk_rise) sdo_q <= sr_q[FRAME_W-1];
            end
        end
    end

    p_commit_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (cnt_q >= CNT_FULL));

    p_sdo_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && !sclk_rise) |=> $stable(sdo_q));
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
    import spi_regs_pkg::*;
#(
    parameter int N_GP    = 4,
    parameter int GP_BASE = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit,
    input  logic               frame_bad,
    input  logic [FRAME_W-1:0] frame_word,
    input  logic               load_ack,
    output logic               rd_pending,
    output logic [FRAME_W-1:0] rd_word,
    output logic               quiet,
    output logic               locked
);
    logic [CMD_W-1:0]  cmd;
    logic [6:0]        addr;
    logic [DATA_W-1:0] wdata;
    logic              wr_en, rd_en, reject, soft_rst;
    logic [DATA_W-1:0] ctrl_q;
    logic              stat_q;
    logic              pend_q;
    logic [FRAME_W-1:0] rdw_q;
    logic [DATA_W-1:0] gp_q [N_GP];
    logic [DATA_W-1:0] rval;

    assign cmd      = frame_word[FRAME_W-1 -: CMD_W];
    assign addr     = cmd[6:0];
    assign wdata    = frame_word[DATA_W-1:0];
    assign locked   = ctrl_q[CTRL_LOCK_BIT];
    assign quiet    = ctrl_q[CTRL_QUIET_BIT];
    assign wr_en    = commit && !locked && !cmd[7];
    assign rd_en    = commit && !locked && cmd[7];
    assign reject   = (commit && locked) || frame_bad;
    assign soft_rst = wr_en && addr == ADDR_SRST && wdata == DATA_W'(1);

    genvar gi;
    generate
        for (gi = 0; gi < N_GP; gi++) begin : g_gp
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                                 gp_q[gi] <= '0;
                else if (soft_rst)                          gp_q[gi] <= '0;
                else if (wr_en && addr == 7'(GP_BASE + gi)) gp_q[gi] <= wdata;
            end
        end
    endgenerate

    always_comb begin
        rval = '0;
        if (addr == ADDR_CTRL) rval = ctrl_q;
        if (addr == ADDR_STAT) rval = {{(DATA_W-1){1'b0}}, stat_q};
        for (int i = 0; i < N_GP; i++)
            if (addr == 7'(GP_BASE + i)) rval = gp_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            stat_q <= 1'b0;
            pend_q <= 1'b0;
            rdw_q  <= '0;
        end else if (soft_rst) begin
            ctrl_q <= '0;
            stat_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            if (wr_en && addr == ADDR_CTRL) ctrl_q <= wdata;
            if (reject) stat_q <= 1'b1;
            else if (rd_en && addr == ADDR_STAT) stat_q <= 1'b0;
            if (rd_en) begin
                pend_q <= 1'b1;
                rdw_q  <= {cmd, rval};
            end else if (load_ack) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign rd_pending = pend_q;
    assign rd_word    = rdw_q;

    p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> locked);

    p_locked_ctrl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && locked) |=> $stable(ctrl_q));

    p_reject_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_bad |=> stat_q);

    p_ack_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_ack |=> !rd_pending);
endmodule

// File: rtl/spi_reg_target.sv
module spi_reg_target
    import spi_regs_pkg::*;
#(
    parameter int N_GP    = 4,
    parameter int GP_BASE = 4,
    parameter int CNT_W   = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic sdi,
    output logic sdo,
    output logic sdo_oe
);
    logic [2:0]         pins_s;
    logic               load_ack, commit, frame_bad;
    logic               rd_pending, quiet, locked;
    logic [FRAME_W-1:0] rd_word, frame_word;

    spi_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sclk, cs_n, sdi}),
        .q     (pins_s)
    );

    spi_frame_engine #(.CNT_W(CNT_W)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_s     (pins_s[2]),
        .cs_n_s     (pins_s[1]),
        .sdi_s      (pins_s[0]),
        .quiet      (quiet),
        .rd_pending (rd_pending),
        .rd_word    (rd_word),
        .sdo        (sdo),
        .sdo_oe     (sdo_oe),
        .load_ack   (load_ack),
        .commit     (commit),
        .frame_bad  (frame_bad),
        .frame_word (frame_word)
    );

    spi_reg_bank #(.N_GP(N_GP), .GP_BASE(GP_BASE)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit     (commit),
        .frame_bad  (frame_bad),
        .frame_word (frame_word),
        .load_ack   (load_ack),
        .rd_pending (rd_pending),
        .rd_word    (rd_word),
        .quiet      (quiet),
        .locked     (locked)
    );

    p_quiet_no_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |-> !sdo_oe);

    p_single_outcome_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit && frame_bad));
endmodule

// File: tb/tb_spi_reg_target.sv
module tb_spi_reg_target;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic cs_n = 1'b1;
    logic sdi = 1'b0;
    logic sdo, sdo_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [47:0] rx;
    logic        oe_all, oe_any;

    always #2.5 clk = ~clk;

    spi_reg_target dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
        .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe)
    );

    task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [47:0] tx, input int n);
        rx = '0;
        oe_all = 1'b1;
        oe_any = 1'b0;
        @(negedge clk) cs_n = 1'b0;
        repeat (6) @(negedge clk);
        for (int i = n - 1; i >= 0; i--) begin
            sdi  = tx[i];
            sclk = 1'b1;
            repeat (6) @(negedge clk);
            rx = {rx[46:0], sdo};
            oe_all &= sdo_oe;
            oe_any |= sdo_oe;
            sclk = 1'b0;
            repeat (6) @(negedge clk);
        end
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic hw_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset_state();
        chk("R11 sdo_oe after reset", {47'b0, sdo_oe}, 48'd0);
        chk("R11 sdo after reset", {47'b0, sdo}, 48'd0);
    endtask

    task automatic t_write_read();
        xfer(48'h041234, 24);
        xfer(48'h84ABCD, 24);
        chk("R3 echo of write frame", rx, 48'h041234);
        xfer(48'h000000, 24);
        chk("R2 R1 readback word", rx, 48'h841234);
        chk("R12 oe high while selected", {47'b0, oe_all}, 48'd1);
        xfer(48'h840000, 24);
        xfer(48'h000000, 24);
        chk("R2 read data bits ignored", rx, 48'h841234);
    endtask

    task automatic t_long_window();
        xfer({16'h0, 8'hAA, 24'h05BEEF}, 32);
        chk("R3 pass-through spill", rx, {16'h0, 24'h000000, 8'hAA});
        xfer(48'h850000, 24);
        chk("R4 echo holds last 24 bits", rx, 48'h05BEEF);
        xfer(48'h000000, 24);
        chk("R4 long window decoded", rx, 48'h85BEEF);
    endtask

    task automatic t_short_window();
        xfer(48'h0455, 16);
        xfer(48'h8B0000, 24);
        xfer(48'h8B0000, 24);
        chk("R9 R5 status set by short window", rx, 48'h8B0001);
        xfer(48'h840000, 24);
        chk("R9 status cleared by read", rx, 48'h8B0000);
        xfer(48'h000000, 24);
        chk("R5 short window wrote nothing", rx, 48'h841234);
    endtask

    task automatic t_unimplemented();
        xfer(48'h20ABCD, 24);
        xfer(48'hA00000, 24);
        xfer(48'h000000, 24);
        chk("R10 unimplemented reads zero", rx, 48'hA00000);
        xfer(48'h0BFFFF, 24);
        xfer(48'h8B0000, 24);
        xfer(48'h000000, 24);
        chk("R9 status ignores writes", rx, 48'h8B0000);
        xfer(48'h840000, 24);
        xfer(48'h000000, 24);
        chk("R10 no-op frames leave register", rx, 48'h841234);
    endtask

    task automatic t_quiet_mode();
        xfer(48'h030010, 24);
        xfer(48'h040999, 24);
        chk("R6 oe low in quiet mode", {47'b0, oe_any}, 48'd0);
        xfer({16'h0, 8'h00, 24'h040777}, 32);
        xfer(48'h840000, 24);
        xfer(48'h000000, 24);
        chk("R6 exact frame kept, long frame dropped", rx, 48'h840999);
    endtask

    task automatic t_soft_reset();
        xfer(48'h010001, 24);
        xfer(48'h840000, 24);
        chk("R7 output enabled again", {47'b0, oe_all}, 48'd1);
        xfer(48'h830000, 24);
        chk("R7 general register defaulted", rx, 48'h840000);
        xfer(48'h000000, 24);
        chk("R7 control register defaulted", rx, 48'h830000);
    endtask

    task automatic t_lockout();
        xfer(48'h0700AA, 24);
        xfer(48'h030001, 24);
        xfer(48'h075555, 24);
        xfer(48'h871111, 24);
        chk("R8 rejected write echoed", rx, 48'h075555);
        xfer(48'h000000, 24);
        chk("R8 rejected read echoed", rx, 48'h871111);
        xfer(48'h010001, 24);
        xfer(48'h871111, 24);
        xfer(48'h000000, 24);
        chk("R8 lock survives soft reset", rx, 48'h871111);
        hw_reset();
        xfer(48'h870000, 24);
        xfer(48'h000000, 24);
        chk("R11 hardware reset clears registers", rx, 48'h870000);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset_state();
        t_write_read();
        t_long_window();
        t_short_window();
        t_unimplemented();
        t_quiet_mode();
        t_soft_reset();
        t_lockout();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule